// File: doc/BRIEF.md
# Security-Banked Exception Priority Arbiter

This block chooses which pending exception should be taken next when requests come from two security states. Two system exceptions, the supervisor call and the system tick, each keep two priority registers, one per security state. A small set of external interrupt lines each belong to one fixed security state, set by a parameter, and each has a single priority register. Software programs these registers through a write port. Every write carries a qualifier that says whether the access is secure. A control bit that only a secure access can change pushes every non-secure priority into the less urgent half of the range. The arbiter picks the winner from the effective priorities of the pending requests.

Each cycle the block reports the winning request as a one-hot vector, together with its security attribute and its effective priority. It also compares that priority with the priority of the running handler, which arrives already in effective form. The result is a preempt flag, registered once. The block only configures and compares. There is no data stream at its edge, so every pin is a plain level with no valid/ready handshake and no back-pressure. Smaller numbers mean more urgent. The idle thread is encoded as 2^PRIO_BITS, one step below the least urgent level that can be programmed.

Top module: `bxp_arbiter`

## Requirements
- R1: The supervisor-call and system-tick priorities each have a secure copy and a non-secure copy. A write with `wr_secure`=1 updates only the secure copy and a write with `wr_secure`=0 updates only the non-secure copy. The supervisor call is at address 1 and the system tick at address 2.
- R2: After reset every priority register holds level 0, the remap bit is 0, `preempt` is 0, and with nothing pending `win_valid` is 0 and `win_onehot` is all zeros.
- R3: Write data is an 8-bit field. The level is taken from its top PRIO_BITS bits, so level L is written as L << (8-PRIO_BITS). All lower bits are ignored.
- R4: When the remap bit is 1, a non-secure level p takes part as min(p + 2^(PRIO_BITS-1), 2^PRIO_BITS - 1), and secure levels are used unchanged. When the remap bit is 0, all levels are used unchanged.
- R5: The remap bit is bit 0 of address 0. Only a write with `wr_secure`=1 changes it, and a non-secure write to address 0 is ignored.
- R6: Among the pending requests, the one with the smallest effective priority wins. `win_onehot` has exactly that source's bit set (bit 0 secure call, 1 non-secure call, 2 secure tick, 3 non-secure tick, 4+k external line k), `win_valid` is 1, and `win_prio` shows its effective level.
- R7: On equal effective priority a secure request beats a non-secure one. Within the same security state the lower exception number wins, in the order supervisor call, system tick, external 0, 1, and so on.
- R8: `preempt` is 1 in the cycle after a cycle in which a winner existed with `win_prio` strictly below `active_prio`, and 0 otherwise. Equal priorities never preempt.
- R9: An `active_prio` of 2^PRIO_BITS stands for the idle thread, and any pending request then raises `preempt` one cycle later.
- R10: External line k is secure when bit k of EXT_SECURE is 1 (default 4'b0101). Its priority is at address 3+k, and a write whose qualifier differs from the line's state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_secure | input | 1 | Write comes from the secure state |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Write data; level in the top PRIO_BITS bits |
| svc_pend | input | 2 | Supervisor call pending; bit 1 secure, bit 0 non-secure |
| tick_pend | input | 2 | System tick pending; bit 1 secure, bit 0 non-secure |
| ext_pend | input | NUM_EXT | External lines pending |
| active_prio | input | PRIO_BITS+1 | Effective priority of the running handler |
| win_onehot | output | NUM_EXT+4 | One-hot winning source |
| win_valid | output | 1 | Some request is pending |
| win_secure | output | 1 | Security state of the winner |
| win_prio | output | PRIO_BITS+1 | Effective level of the winner |
| preempt | output | 1 | Registered: winner outranks the running handler |

## Verification
The assertions assume that `active_prio` never goes above the idle encoding 2^PRIO_BITS. They also assume that the write inputs are quiet while reset is asserted, so no check looks at history from before reset. The stimulus draws `active_prio` only from 0 to 2^PRIO_BITS and keeps `wr_en` low during reset. Writes land on every address, including ones that decode to nothing, and carry both qualifiers. A behavioural model predicts the winner and the flag every cycle, and directed steps cover equal-priority ties, saturation of the remap, and writes the block must ignore.

// File: rtl/bxp_pkg.sv
package bxp_pkg;
  // width of a priority field as seen on the write port
  localparam int FIELD_W = 8;

  // register address map
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_SVC  = 1;
  localparam int ADDR_TICK = 2;
  localparam int ADDR_EXT0 = 3;
  localparam int CTRL_REMAP_BIT = 0;

  // source slots, ordered by exception number, secure copy first
  localparam int SRC_SVC_S   = 0;
  localparam int SRC_SVC_NS  = 1;
  localparam int SRC_TICK_S  = 2;
  localparam int SRC_TICK_NS = 3;
  localparam int SRC_EXT0    = 4;
endpackage

// File: rtl/bxp_prio_bank.sv
module bxp_prio_bank
  import bxp_pkg::*;
#(
  parameter int PRIO_BITS = 3,
  parameter int NUM_EXT   = 4,
  parameter int ADDR_W    = 4,
  parameter logic [NUM_EXT-1:0] EXT_SECURE = '0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic                              wr_secure,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [FIELD_W-1:0]                wr_data,
  output logic                              remap_o,
  output logic [PRIO_BITS-1:0]              svc_s_o,
  output logic [PRIO_BITS-1:0]              svc_ns_o,
  output logic [PRIO_BITS-1:0]              tick_s_o,
  output logic [PRIO_BITS-1:0]              tick_ns_o,
  output logic [NUM_EXT-1:0][PRIO_BITS-1:0] ext_o
);
  localparam int LVL_LSB = FIELD_W - PRIO_BITS;

  logic [PRIO_BITS-1:0] wr_lvl;
  logic                 hit_ctrl, hit_svc, hit_tick;
  logic [1:0][PRIO_BITS-1:0] svc_q, tick_q;   // index 1 = secure copy
  logic                 unused_wr_bits;

  assign wr_lvl         = wr_data[FIELD_W-1:LVL_LSB];
  assign unused_wr_bits = ^wr_data;
  assign hit_ctrl = wr_en && (int'(wr_addr) == ADDR_CTRL);
  assign hit_svc  = wr_en && (int'(wr_addr) == ADDR_SVC);
  assign hit_tick = wr_en && (int'(wr_addr) == ADDR_TICK);

  // remap control: secure writers only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    remap_o <= 1'b0;
    else if (hit_ctrl && wr_secure) remap_o <= wr_data[CTRL_REMAP_BIT];
  end

  // banked system exception priorities, one copy per security state
  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        svc_q[b]  <= '0;
        tick_q[b] <= '0;
      end else begin
        if (hit_svc  && (wr_secure == 1'(b))) svc_q[b]  <= wr_lvl;
        if (hit_tick && (wr_secure == 1'(b))) tick_q[b] <= wr_lvl;
      end
    end
  end

  // external lines: writable only from the state the line belongs to
  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
    logic hit_ext;
    assign hit_ext = wr_en && (int'(wr_addr) == ADDR_EXT0 + k) &&
                     (wr_secure == EXT_SECURE[k]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ext_o[k] <= '0;
      else if (hit_ext) ext_o[k] <= wr_lvl;
    end
  end

  assign svc_s_o   = svc_q[1];
  assign svc_ns_o  = svc_q[0];
  assign tick_s_o  = tick_q[1];
  assign tick_ns_o = tick_q[0];
endmodule

// File: rtl/bxp_remap.sv
module bxp_remap #(
  parameter int PRIO_BITS = 3
) (
  input  logic [PRIO_BITS-1:0] level_i,
  input  logic                 secure_i,
  input  logic                 remap_i,
  output logic [PRIO_BITS:0]   eff_o
);
  localparam int LVL_W = PRIO_BITS + 1;
  localparam logic [LVL_W-1:0] HALF = LVL_W'(1 << (PRIO_BITS - 1));
  localparam logic [LVL_W-1:0] MAXL = LVL_W'((1 << PRIO_BITS) - 1);

  logic [LVL_W-1:0] plain, shifted;

  assign plain   = {1'b0, level_i};
  assign shifted = plain + HALF;

  always_comb begin
    if (remap_i && !secure_i) eff_o = (shifted > MAXL) ? MAXL : shifted;
    else                      eff_o = plain;
  end
endmodule

// File: rtl/bxp_select.sv
module bxp_select #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 4
) (
  input  logic [NUM_SRC-1:0]            pend_i,
  input  logic [NUM_SRC-1:0]            sec_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] prio_i,
  output logic [NUM_SRC-1:0]            onehot_o,
  output logic                          valid_o,
  output logic                          secure_o,
  output logic [LVL_W-1:0]              prio_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int KEY_W = LVL_W + 1;

  logic [IDX_W-1:0] best_idx;
  logic [KEY_W-1:0] best_key;
  logic             found;

  // key = {level, not-secure}: lower wins; scan keeps the lower index on a tie
  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_key = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i] && (!found || {prio_i[i], ~sec_i[i]} < best_key)) begin
        found    = 1'b1;
        best_idx = IDX_W'(i);
        best_key = {prio_i[i], ~sec_i[i]};
      end
    end
  end

  always_comb begin
    onehot_o = '0;
    if (found) onehot_o[best_idx] = 1'b1;
  end

  assign valid_o  = found;
  assign secure_o = found && !best_key[0];
  assign prio_o   = found ? best_key[KEY_W-1:1] : '0;
endmodule

// File: rtl/bxp_arbiter.sv
module bxp_arbiter
  import bxp_pkg::*;
#(
  parameter int PRIO_BITS = 3,
  parameter int NUM_EXT   = 4,
  parameter int ADDR_W    = 4,
  parameter logic [NUM_EXT-1:0] EXT_SECURE = 4'b0101
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   wr_secure,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [7:0]             wr_data,
  input  logic [1:0]             svc_pend,
  input  logic [1:0]             tick_pend,
  input  logic [NUM_EXT-1:0]     ext_pend,
  input  logic [PRIO_BITS:0]     active_prio,
  output logic [NUM_EXT+3:0]     win_onehot,
  output logic                   win_valid,
  output logic                   win_secure,
  output logic [PRIO_BITS:0]     win_prio,
  output logic                   preempt
);
  localparam int NUM_SRC = NUM_EXT + 4;
  localparam int LVL_W   = PRIO_BITS + 1;

  logic                              remap_q;
  logic [PRIO_BITS-1:0]              svc_s_lvl, svc_ns_lvl, tick_s_lvl, tick_ns_lvl;
  logic [NUM_EXT-1:0][PRIO_BITS-1:0] ext_lvl;
  logic [NUM_SRC-1:0][PRIO_BITS-1:0] raw_lvl;
  logic [NUM_SRC-1:0][LVL_W-1:0]     eff_lvl;
  logic [NUM_SRC-1:0]                src_sec, src_pend;
  logic                              preempt_q;

  bxp_prio_bank #(
    .PRIO_BITS(PRIO_BITS), .NUM_EXT(NUM_EXT), .ADDR_W(ADDR_W), .EXT_SECURE(EXT_SECURE)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_secure(wr_secure),
    .wr_addr(wr_addr), .wr_data(wr_data), .remap_o(remap_q),
    .svc_s_o(svc_s_lvl), .svc_ns_o(svc_ns_lvl),
    .tick_s_o(tick_s_lvl), .tick_ns_o(tick_ns_lvl), .ext_o(ext_lvl)
  );

  // source table in exception-number order
  assign raw_lvl[SRC_SVC_S]   = svc_s_lvl;
  assign raw_lvl[SRC_SVC_NS]  = svc_ns_lvl;
  assign raw_lvl[SRC_TICK_S]  = tick_s_lvl;
  assign raw_lvl[SRC_TICK_NS] = tick_ns_lvl;
  assign src_sec[3:0]  = 4'b0101;
  assign src_pend[3:0] = {tick_pend[0], tick_pend[1], svc_pend[0], svc_pend[1]};

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext_src
    assign raw_lvl[SRC_EXT0+k]  = ext_lvl[k];
    assign src_sec[SRC_EXT0+k]  = EXT_SECURE[k];
    assign src_pend[SRC_EXT0+k] = ext_pend[k];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_remap
    bxp_remap #(.PRIO_BITS(PRIO_BITS)) u_remap (
      .level_i(raw_lvl[i]), .secure_i(src_sec[i]),
      .remap_i(remap_q), .eff_o(eff_lvl[i])
    );
  end

  bxp_select #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_select (
    .pend_i(src_pend), .sec_i(src_sec), .prio_i(eff_lvl),
    .onehot_o(win_onehot), .valid_o(win_valid),
    .secure_o(win_secure), .prio_o(win_prio)
  );

  // strict comparison: an equal level never preempts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) preempt_q <= 1'b0;
    else        preempt_q <= win_valid && (win_prio < active_prio);
  end

  assign preempt = preempt_q;
endmodule

// File: rtl/bxp_arbiter_chk.sv
module bxp_arbiter_chk #(
  parameter int PRIO_BITS = 3,
  parameter int NUM_EXT   = 4,
  parameter int ADDR_W    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 wr_secure,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [1:0]           svc_pend,
  input logic [1:0]           tick_pend,
  input logic [NUM_EXT-1:0]   ext_pend,
  input logic [PRIO_BITS:0]   active_prio,
  input logic [NUM_EXT+3:0]   win_onehot,
  input logic                 win_valid,
  input logic                 win_secure,
  input logic [PRIO_BITS:0]   win_prio,
  input logic                 preempt,
  input logic                 remap_q,
  input logic [PRIO_BITS-1:0] svc_ns_lvl
);
  localparam int LVL_W = PRIO_BITS + 1;
  localparam logic [LVL_W-1:0] HALF = LVL_W'(1 << (PRIO_BITS - 1));
  localparam logic [LVL_W-1:0] MAXL = LVL_W'((1 << PRIO_BITS) - 1);
  localparam logic [LVL_W-1:0] IDLE = LVL_W'(1 << PRIO_BITS);

  logic [NUM_EXT+3:0] pend_all;
  assign pend_all = {ext_pend, tick_pend[0], tick_pend[1], svc_pend[0], svc_pend[1]};

  AST_WIN_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> $countones(win_onehot) == 1); // R6
  AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (win_onehot & ~pend_all) == '0); // R6
  AST_NS_LOWER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (remap_q && win_valid && !win_secure) |-> win_prio >= HALF); // R4
  AST_PRIO_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> win_prio <= MAXL); // R4
  AST_REMAP_NS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_secure && wr_addr == '0) |=> $stable(remap_q)); // R5
  AST_BANK_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_secure && wr_addr == ADDR_W'(1)) |=> $stable(svc_ns_lvl)); // R1
  AST_NO_PREEMPT_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_valid || win_prio >= active_prio) |=> !preempt); // R8
  AST_IDLE_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && active_prio == IDLE) |=> preempt); // R9
endmodule

bind bxp_arbiter bxp_arbiter_chk #(
  .PRIO_BITS(PRIO_BITS), .NUM_EXT(NUM_EXT), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_secure(wr_secure),
  .wr_addr(wr_addr), .svc_pend(svc_pend), .tick_pend(tick_pend),
  .ext_pend(ext_pend), .active_prio(active_prio), .win_onehot(win_onehot),
  .win_valid(win_valid), .win_secure(win_secure), .win_prio(win_prio),
  .preempt(preempt), .remap_q(remap_q), .svc_ns_lvl(svc_ns_lvl)
);

// File: tb/bxp_arbiter_test.sv
`timescale 1ns/1ps
module bxp_arbiter_test;
  localparam int N    = 3;
  localparam int NE   = 4;
  localparam int NSRC = NE + 4;
  localparam int AW   = 4;
  localparam int HALF = 1 << (N - 1);
  localparam int MAXL = (1 << N) - 1;
  localparam int IDLE = 1 << N;
  localparam logic [NE-1:0] EXT_SEC = 4'b0101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_secure = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] svc_pend = '0, tick_pend = '0;
  logic [NE-1:0] ext_pend = '0;
  logic [N:0] active_prio = N'(0) + (N+1)'(IDLE);
  logic [NE+3:0] win_onehot;
  logic win_valid, win_secure, preempt;
  logic [N:0] win_prio;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state; bank index 1 = secure
  int m_remap = 0;
  int m_svc[2] = '{0, 0};
  int m_tick[2] = '{0, 0};
  int m_ext[NE] = '{default: 0};

  bxp_arbiter #(.PRIO_BITS(N), .NUM_EXT(NE), .ADDR_W(AW), .EXT_SECURE(EXT_SEC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_secure(wr_secure),
    .wr_addr(wr_addr), .wr_data(wr_data), .svc_pend(svc_pend),
    .tick_pend(tick_pend), .ext_pend(ext_pend), .active_prio(active_prio),
    .win_onehot(win_onehot), .win_valid(win_valid), .win_secure(win_secure),
    .win_prio(win_prio), .preempt(preempt)
  );

  always #4 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff(int lvl, bit sec);
    int e = lvl;
    if (!sec && m_remap != 0) begin
      e = lvl + HALF;
      if (e > MAXL) e = MAXL;
    end
    return e;
  endfunction

  task automatic model_win(output int idx, output bit valid, output bit sec, output int prio);
    valid = 0; idx = 0; sec = 0; prio = 0;
    for (int i = 0; i < NSRC; i++) begin
      int lvl; bit s; bit p;
      case (i)
        0: begin lvl = m_svc[1];  s = 1; p = svc_pend[1];  end
        1: begin lvl = m_svc[0];  s = 0; p = svc_pend[0];  end
        2: begin lvl = m_tick[1]; s = 1; p = tick_pend[1]; end
        3: begin lvl = m_tick[0]; s = 0; p = tick_pend[0]; end
        default: begin lvl = m_ext[i-4]; s = EXT_SEC[i-4]; p = ext_pend[i-4]; end
      endcase
      if (p) begin
        int e = eff(lvl, s);
        if (!valid || e < prio || (e == prio && s && !sec)) begin
          valid = 1; idx = i; sec = s; prio = e;
        end
      end
    end
  endtask

  task automatic model_write();
    int lvl = int'(wr_data) >> (8 - N);
    int a = int'(wr_addr);
    if (!wr_en) return;
    if (a == 0 && wr_secure) m_remap = wr_data[0];
    else if (a == 1) m_svc[wr_secure] = lvl;
    else if (a == 2) m_tick[wr_secure] = lvl;
    else if (a >= 3 && a < 3 + NE && wr_secure == EXT_SEC[a-3]) m_ext[a-3] = lvl;
  endtask

  // one clock: compare outputs, advance model, compare the registered flag
  task automatic cycle();
    int idx, p; bit v, s; int exp_oh; bit nxt;
    #1;
    model_win(idx, v, s, p);
    exp_oh = v ? (1 << idx) : 0;
    check("R6 win_onehot", int'(win_onehot), exp_oh);
    check("R6 win_valid", int'(win_valid), int'(v));
    if (v) begin
      check("R7 win_secure", int'(win_secure), int'(s));
      check("R4 win_prio", int'(win_prio), p);
    end
    nxt = v && (p < int'(active_prio));
    @(posedge clk);
    model_write();
    @(negedge clk);
    check("R8 preempt", int'(preempt), int'(nxt));
    wr_en = 1'b0;
  endtask

  task automatic wr(bit sec, int addr, int data);
    wr_en = 1'b1; wr_secure = sec; wr_addr = AW'(addr); wr_data = 8'(data);
    cycle();
  endtask

  task automatic pend(logic [1:0] sv, logic [1:0] tk, logic [NE-1:0] ex, int act);
    svc_pend = sv; tick_pend = tk; ext_pend = ex; active_prio = (N+1)'(act);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 preempt in reset", int'(preempt), 0);
    check("R2 win_valid idle", int'(win_valid), 0);
    check("R2 win_onehot idle", int'(win_onehot), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // reset levels and idle preemption
    pend(2'b01, 2'b00, '0, IDLE); #1;
    check("R2 ns call reset level", int'(win_prio), 0);
    cycle();
    check("R9 idle preempted", int'(preempt), 1);

    // banking
    wr(1, 1, 8'h20);
    pend(2'b01, 2'b00, '0, IDLE); #1;
    check("R1 ns call untouched by secure write", int'(win_prio), 0);
    pend(2'b10, 2'b00, '0, IDLE); #1;
    check("R1 secure call written", int'(win_prio), 1);
    wr(0, 1, 8'h60);
    #1; check("R1 secure call untouched by ns write", int'(win_prio), 1);

    // remap bit protection and remap
    wr(0, 0, 1);
    pend(2'b01, 2'b00, '0, IDLE); #1;
    check("R5 ns write to remap ignored", int'(win_prio), 3);
    wr(1, 0, 1);
    #1; check("R4 ns call 3 remapped", int'(win_prio), 7);
    wr(0, 1, 8'h00);
    #1; check("R4 ns call 0 remapped", int'(win_prio), 4);

    // field format
    wr(1, 2, 8'h5F);
    pend(2'b00, 2'b10, '0, IDLE); #1;
    check("R3 low bits ignored", int'(win_prio), 2);

    // saturation
    wr(0, 2, 8'hA0);
    pend(2'b00, 2'b01, '0, IDLE); #1;
    check("R4 saturate at lowest level", int'(win_prio), MAXL);

    // equal effective level: secure wins, no preempt at equal level
    wr(1, 2, 8'h80);
    pend(2'b01, 2'b10, '0, 4); #1;
    check("R7 tie secure tick onehot", int'(win_onehot), 4);
    check("R7 tie secure flag", int'(win_secure), 1);
    cycle();
    check("R8 equal does not preempt", int'(preempt), 0);
    pend(2'b01, 2'b10, '0, 5);
    cycle();
    check("R8 strictly higher preempts", int'(preempt), 1);

    // same security, lower exception number
    wr(0, 4, 8'h40);
    wr(0, 6, 8'h40);
    pend(2'b00, 2'b00, 4'b1010, IDLE); #1;
    check("R7 lower number wins", int'(win_onehot), 1 << 5);
    check("R7 remapped ext level", int'(win_prio), 6);

    // external line security filter
    wr(1, 3, 8'hE0);
    wr(0, 3, 8'h20);
    pend(2'b00, 2'b00, 4'b0001, IDLE); #1;
    check("R10 ns write to secure line ignored", int'(win_prio), 7);
    check("R10 line secure", int'(win_secure), 1);
    cycle();
    check("R9 idle preempted by ext", int'(preempt), 1);
    pend(2'b00, 2'b00, 4'b0001, 7);
    cycle();
    check("R8 equal ext level", int'(preempt), 0);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      pend(2'($urandom), 2'($urandom), NE'($urandom), int'($urandom_range(0, IDLE)));
      if ($urandom_range(0, 3) == 0) wr(1'($urandom), int'($urandom_range(0, 8)), int'($urandom_range(0, 255)));
      else cycle();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule